// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This block steps through a fixed, numbered list of built-in self tests right after reset. For each test it first puts the test's number on a 4-bit binary code display. One cycle later it pulses a start strobe to the external test engines. It then waits for a done strobe that comes with a pass/fail bit. A passing result moves the sequence to the next number. When every test has passed or been bypassed, the block raises an operational flag and releases the audio mute. The mute is held from reset until that point.

A failing result stops the sequence. The failing code stays on the display, a failure indicator turns on, and the audio stays muted. Three debounced button pulses choose what happens next. Bypass moves on to the following test and clears the indicator. Store hands control to an extended-diagnostics mode and halts the normal list for good. Tap reruns the failed test over and over, with no end. Buttons only count while the sequencer is halted on a failure. A press at any other time has no effect. The test engines and the extended-diagnostics mode itself are outside this block.

Top module: `post_sequencer`

## Requirements
- R1: While reset is asserted the display shows code 1, and the start strobe, failure indicator, operational flag and extended-diagnostics flag are all 0 while the mute is 1.
- R2: The display shows the code of the next test (its position in the list plus one, 4 bits, MSB first) at least one cycle before that test's start strobe, and holds it unchanged through the strobe.
- R3: The start strobe is a single-cycle pulse. After a passing done that is not for the last test, the display shows the next code on the following cycle and the strobe follows one cycle later.
- R4: A failing done turns on the failure indicator on the next cycle, leaves the failing code on the display, and issues no new start until a button acts.
- R5: The mute stays 1 and the operational flag stays 0 for as long as the sequencer is halted on a failure, looping, or in extended diagnostics.
- R6: While halted, a bypass pulse shows the next code and clears the failure indicator on the following cycle. This works again at every later failure.
- R7: A bypass pulse while halted on the last test raises the operational flag, clears the failure indicator and drops the mute on the following cycle.
- R8: While halted, a store pulse raises the extended-diagnostics flag on the following cycle. The flag then stays 1, no further start strobe is issued, and later buttons have no effect.
- R9: While halted, a tap pulse restarts the failed test with the same code. After every later done, pass or fail, the test restarts again. The failure indicator stays lit, and later buttons have no effect.
- R10: When several buttons arrive in the same cycle while halted, store wins over bypass, and bypass wins over tap.
- R11: A button pulse that arrives while a test is being shown, started or run, including in the same cycle as that test's failing done, has no effect.
- R12: If every test passes, the operational flag rises and the mute drops on the cycle after the last done. Both then hold and no start strobe follows.
- R13: The tests run in list order with codes 1, 2, 3 for the default three-entry list: ROM checksum, SRAM pattern test, then the wavetable/control-store test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_bypass | input | 1 | Debounced one-cycle bypass press |
| btn_store | input | 1 | Debounced one-cycle store press |
| btn_tap | input | 1 | Debounced one-cycle tap press |
| test_done | input | 1 | One-cycle completion strobe from the running test engine |
| test_pass | input | 1 | Result qualifying test_done (1 = pass) |
| test_start | output | 1 | One-cycle start strobe to the engine chosen by test_code |
| test_code | output | CODE_W | Number of the current test, also the binary display value |
| fail_led | output | 1 | Failure indicator |
| audio_mute | output | 1 | Audio mute control, 1 = muted |
| sys_ready | output | 1 | Operational flag |
| ext_diag | output | 1 | Extended-diagnostics mode flag |

## Verification
Two events can land in the same clock: a test engine's failing done and a button press. The bench provokes this by waiting for the done strobe to be visible and pressing tap in that very cycle. It then judges that the press was dropped: the sequencer halts with the indicator lit and issues no restart. A second collision is several buttons pressed at once while halted. All three together must give extended diagnostics, and bypass with tap must give a skip. Each cycle is also compared against a behavioural model of the sequence.

// File: rtl/post_pkg.sv
package post_pkg;

    typedef enum logic [2:0] {
        ST_SHOW   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_RUN    = 3'd2,
        ST_HALT   = 3'd3,
        ST_PASSED = 3'd4,
        ST_DIAG   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_DIAG = 2'd1,
        ACT_SKIP = 2'd2,
        ACT_LOOP = 2'd3
    } fail_act_e;

endpackage

// File: rtl/post_btn_arb.sv
module post_btn_arb
    import post_pkg::*;
(
    input  logic      enable,
    input  logic      req_skip,
    input  logic      req_diag,
    input  logic      req_loop,
    output fail_act_e act
);

    always_comb begin
        act = ACT_NONE;
        if (enable) begin
            if (req_diag) begin
                act = ACT_DIAG;
            end else if (req_skip) begin
                act = ACT_SKIP;
            end else if (req_loop) begin
                act = ACT_LOOP;
            end
        end
    end

endmodule

// File: rtl/post_code_map.sv
module post_code_map #(
    parameter int NUM_TESTS = 3,
    parameter int CODE_W    = 4,
    parameter int IDX_W     = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [CODE_W-1:0] code,
    output logic              is_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TESTS - 1);

    generate
        if (CODE_W > IDX_W) begin : g_wide
            assign code = {{(CODE_W-IDX_W){1'b0}}, idx} + CODE_W'(1);
        end else begin : g_narrow
            assign code = idx[CODE_W-1:0] + CODE_W'(1);
        end
    endgenerate

    assign is_last = (idx == LAST_IDX);

endmodule

// File: rtl/post_sequencer.sv
module post_sequencer
    import post_pkg::*;
#(
    parameter int NUM_TESTS = 3,
    parameter int CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_bypass,
    input  logic              btn_store,
    input  logic              btn_tap,
    input  logic              test_done,
    input  logic              test_pass,
    output logic              test_start,
    output logic [CODE_W-1:0] test_code,
    output logic              fail_led,
    output logic              audio_mute,
    output logic              sys_ready,
    output logic              ext_diag
);

    localparam int IDX_W = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             looping;
        logic             fail;
        logic             mute;
        logic             ready;
        logic             diag;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state:   ST_SHOW,
        idx:     '0,
        looping: 1'b0,
        fail:    1'b0,
        mute:    1'b1,
        ready:   1'b0,
        diag:    1'b0
    };

    seq_regs_t seq_d, seq_q;
    fail_act_e act;
    logic      halted;
    logic      last_test;

    assign halted = (seq_q.state == ST_HALT);

    post_btn_arb u_arb (
        .enable   (halted),
        .req_skip (btn_bypass),
        .req_diag (btn_store),
        .req_loop (btn_tap),
        .act      (act)
    );

    post_code_map #(
        .NUM_TESTS (NUM_TESTS),
        .CODE_W    (CODE_W),
        .IDX_W     (IDX_W)
    ) u_map (
        .idx     (seq_q.idx),
        .code    (test_code),
        .is_last (last_test)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_SHOW: begin
                seq_d.state = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                seq_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (test_done) begin
                    if (seq_q.looping) begin
                        seq_d.state = ST_SHOW;
                    end else if (test_pass) begin
                        if (last_test) begin
                            seq_d.state = ST_PASSED;
                            seq_d.ready = 1'b1;
                            seq_d.mute  = 1'b0;
                        end else begin
                            seq_d.idx   = seq_q.idx + IDX_W'(1);
                            seq_d.state = ST_SHOW;
                        end
                    end else begin
                        seq_d.fail  = 1'b1;
                        seq_d.state = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                unique case (act)
                    ACT_DIAG: begin
                        seq_d.diag  = 1'b1;
                        seq_d.state = ST_DIAG;
                    end
                    ACT_SKIP: begin
                        seq_d.fail = 1'b0;
                        if (last_test) begin
                            seq_d.state = ST_PASSED;
                            seq_d.ready = 1'b1;
                            seq_d.mute  = 1'b0;
                        end else begin
                            seq_d.idx   = seq_q.idx + IDX_W'(1);
                            seq_d.state = ST_SHOW;
                        end
                    end
                    ACT_LOOP: begin
                        seq_d.looping = 1'b1;
                        seq_d.state   = ST_SHOW;
                    end
                    default: begin
                    end
                endcase
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= RESET_VAL;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign test_start = (seq_q.state == ST_LAUNCH);
    assign fail_led   = seq_q.fail;
    assign audio_mute = seq_q.mute;
    assign sys_ready  = seq_q.ready;
    assign ext_diag   = seq_q.diag;

endmodule

module post_sequencer_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              btn_bypass,
    input logic              test_start,
    input logic [CODE_W-1:0] test_code,
    input logic              fail_led,
    input logic              audio_mute,
    input logic              sys_ready,
    input logic              ext_diag
);

    assert_start_code_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        test_start |-> $stable(test_code));

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        test_start |=> !test_start);

    assert_fail_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_led && !btn_bypass) |=> fail_led);

    assert_fail_keeps_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fail_led |-> (audio_mute && !sys_ready));

    assert_diag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_diag |=> (ext_diag && !test_start && audio_mute));

    assert_ready_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ready |=> (sys_ready && !audio_mute && !test_start));

endmodule

bind post_sequencer post_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_bypass (btn_bypass),
    .test_start (test_start),
    .test_code  (test_code),
    .fail_led   (fail_led),
    .audio_mute (audio_mute),
    .sys_ready  (sys_ready),
    .ext_diag   (ext_diag)
);

// File: tb/post_sequencer_bench.sv
module post_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_bypass = 1'b0, btn_store = 1'b0, btn_tap = 1'b0;
    logic       test_done, test_pass;
    logic       test_start;
    logic [3:0] test_code;
    logic       fail_led, audio_mute, sys_ready, ext_diag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    logic plan [1:15];
    int   starts[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    post_sequencer #(.NUM_TESTS(N), .CODE_W(4)) u_post_sequencer (
        .clk(clk), .rst_n(rst_n),
        .btn_bypass(btn_bypass), .btn_store(btn_store), .btn_tap(btn_tap),
        .test_done(test_done), .test_pass(test_pass),
        .test_start(test_start), .test_code(test_code),
        .fail_led(fail_led), .audio_mute(audio_mute),
        .sys_ready(sys_ready), .ext_diag(ext_diag)
    );

    // test engine: answers 3 cycles after a start strobe
    logic       eng_busy;
    int         eng_cnt;
    logic [3:0] eng_code;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_busy <= 1'b0; eng_cnt <= 0; eng_code <= 4'd0;
            test_done <= 1'b0; test_pass <= 1'b0;
        end else begin
            test_done <= 1'b0;
            if (eng_busy) begin
                if (eng_cnt == 0) begin
                    test_done <= 1'b1;
                    test_pass <= plan[eng_code];
                    eng_busy  <= 1'b0;
                end else begin
                    eng_cnt <= eng_cnt - 1;
                end
            end
            if (test_start) begin
                eng_busy <= 1'b1; eng_cnt <= 2; eng_code <= test_code;
            end
        end
    end

    // behavioural reference: 0 show, 1 start, 2 run, 3 halted, 4 ready, 5 diag
    int m_ph, m_idx;
    bit m_fail, m_loop;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_fail = 0; m_loop = 0;
        end else begin
            case (m_ph)
                0: m_ph = 1;
                1: m_ph = 2;
                2: if (test_done) begin
                    if (m_loop) m_ph = 0;
                    else if (test_pass) begin
                        if (m_idx == N-1) m_ph = 4;
                        else begin m_idx++; m_ph = 0; end
                    end else begin
                        m_fail = 1; m_ph = 3;
                    end
                end
                3: if (btn_store) m_ph = 5;
                   else if (btn_bypass) begin
                       m_fail = 0;
                       if (m_idx == N-1) m_ph = 4;
                       else begin m_idx++; m_ph = 0; end
                   end else if (btn_tap) begin
                       m_loop = 1; m_ph = 0;
                   end
                default: ;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check(test_code == 4'(m_idx + 1), "R2 code", test_code, m_idx + 1);
            check(test_start == (m_ph == 1), "R3 start", test_start, m_ph == 1);
            check(fail_led == m_fail, "R4 fail_led", fail_led, m_fail);
            check(audio_mute == (m_ph != 4), "R5 mute", audio_mute, m_ph != 4);
            check(sys_ready == (m_ph == 4), "R12 ready", sys_ready, m_ph == 4);
            check(ext_diag == (m_ph == 5), "R8 ext_diag", ext_diag, m_ph == 5);
        end
        if (rst_n && test_start) starts.push_back(int'(test_code));
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 60000);
            finish_run();
        end
    end

    task automatic do_reset(input logic p1, input logic p2, input logic p3);
        cmp_en = 1'b0;
        rst_n = 1'b0;
        btn_bypass = 0; btn_store = 0; btn_tap = 0;
        plan[1] = p1; plan[2] = p2; plan[3] = p3;
        repeat (3) @(negedge clk);
        starts.delete();
        // R1 reset state
        check(test_code == 4'd1 && !test_start && !fail_led && audio_mute && !sys_ready && !ext_diag,
              "R1 reset", {test_code, test_start, fail_led, audio_mute, sys_ready, ext_diag}, 9'b0001_0010_0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
    endtask

    task automatic press(input logic s, input logic d, input logic l);
        btn_bypass = s; btn_store = d; btn_tap = l;
        @(negedge clk);
        btn_bypass = 0; btn_store = 0; btn_tap = 0;
    endtask

    task automatic wait_fail();
        for (int i = 0; i < 200 && !fail_led; i++) @(negedge clk);
    endtask

    task automatic wait_done_of(input int c);
        for (int i = 0; i < 200 && !(test_done && test_code == 4'(c)); i++) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && !sys_ready; i++) @(negedge clk);
    endtask

    initial begin
        // all pass, with a tap press while test 1 runs (R11, R12, R13)
        do_reset(1, 1, 1);
        repeat (4) @(negedge clk);
        press(0, 0, 1);
        wait_ready();
        check(sys_ready && !audio_mute, "R12 ready after all pass", sys_ready, 1);
        check(starts.size() == 3, "R13 start count", starts.size(), 3);
        for (int i = 0; i < starts.size() && i < 3; i++)
            check(starts[i] == i + 1, "R13 code order", starts[i], i + 1);
        repeat (10) @(negedge clk);
        check(starts.size() == 3, "R12 no start after ready", starts.size(), 3);

        // test 2 fails; tap in the same cycle as the failing done (R11), then bypass (R6)
        do_reset(1, 0, 1);
        wait_done_of(2);
        press(0, 0, 1);
        check(fail_led && test_code == 4'd2, "R4 halted on code 2", test_code, 2);
        repeat (10) @(negedge clk);
        check(starts.size() == 2, "R11 same-cycle tap ignored", starts.size(), 2);
        check(audio_mute && !sys_ready, "R5 muted while halted", audio_mute, 1);
        press(1, 0, 0);
        check(test_code == 4'd3 && !fail_led, "R6 bypass to code 3", test_code, 3);
        wait_ready();
        check(sys_ready, "R6 finishes after bypass", sys_ready, 1);

        // tests 1 and 3 fail; bypass twice, the last reaching ready (R6, R7)
        do_reset(0, 1, 0);
        wait_fail();
        press(1, 0, 0);
        check(test_code == 4'd2 && !fail_led, "R6 first bypass", test_code, 2);
        wait_fail();
        check(test_code == 4'd3, "R6 second failure code", test_code, 3);
        press(1, 0, 0);
        check(sys_ready && !audio_mute && !fail_led, "R7 bypass last gives ready", sys_ready, 1);

        // all three buttons together -> store wins (R10, R8)
        do_reset(0, 1, 1);
        wait_fail();
        press(1, 1, 1);
        check(ext_diag == 1'b1, "R10 store beats others", ext_diag, 1);
        repeat (5) @(negedge clk);
        press(1, 0, 0);
        press(0, 0, 1);
        repeat (10) @(negedge clk);
        check(ext_diag && audio_mute && starts.size() == 1, "R8 diag holds, no starts", starts.size(), 1);
        check(test_code == 4'd1, "R8 code kept", test_code, 1);

        // bypass together with tap -> bypass wins (R10)
        do_reset(1, 0, 1);
        wait_fail();
        press(1, 0, 1);
        check(test_code == 4'd3 && !fail_led, "R10 bypass beats tap", test_code, 3);
        wait_ready();

        // tap loops the failed test forever (R9)
        do_reset(0, 1, 1);
        wait_fail();
        press(0, 0, 1);
        repeat (30) @(negedge clk);
        plan[1] = 1'b1;
        press(1, 0, 0);
        press(0, 1, 0);
        repeat (60) @(negedge clk);
        check(starts.size() >= 8, "R9 repeated restarts", starts.size(), 8);
        begin
            int bad = 0;
            foreach (starts[i]) if (starts[i] != 1) bad++;
            check(bad == 0, "R9 same code every restart", bad, 0);
        end
        check(fail_led && !sys_ready && !ext_diag, "R9 fail lit, buttons ignored", fail_led, 1);

        cmp_en = 1'b0;
        finish_run();
    end

endmodule